// File: doc/BRIEF.md
# Guarded Clock Configuration Register Bank

This block holds the clock setup of a chip in a handful of bus-visible registers: the enables of a high-speed and a low-speed oscillator, a two-bit clock source select, the PLL power switch, the PLL multiplier, and the settings of the wake-up stabilization wait. Software reaches it through a plain synchronous register port. A write strobe, a byte address and a 16-bit write value are sampled on the rising clock edge. Read data is combinational from the address. There is no data stream at this edge, so the port has no valid/ready handshake and cannot apply back-pressure: every write is either applied or refused in the cycle it is presented.

Two guards protect the configuration. First, the whole protected window (byte addresses 0x00 to 0x14) accepts writes only after the key value has been written to the key register. The bank stays open until some other value is written there. Second, the PLL multiplier is frozen while the PLL is powered or selected as the clock source. Every refused write raises a sticky flag, which software clears by writing 1 to it.

A wake pulse starts the stabilization wait. The wait counts cycles of whichever source the select field names at that moment. Each source delivers a one-cycle strobe on `src_tick`, and the strobe of the selected source drives the count. `clock_ready` falls for the programmed number of ticks and rises again when the count runs out.

Top module: `clkcfg_guard`

## Requirements
- R1: After reset, reads return 0x0003 at 0x08, 0x0000 at 0x0C, 0x10, 0x20 and 0x24, and 0xFF00 at 0x14. `clock_ready` is 1.
- R2: While locked, a write to any byte address from 0x00 to 0x14 changes no register.
- R3: Writing exactly 0x0096 to 0x24 unlocks the bank, and it stays unlocked through any number of other writes. Writing any other value to 0x24 locks it. Address 0x24 reads bit 0 = 1 when unlocked and 0 when locked.
- R4: Address 0x08 holds the low-speed oscillator enable in bit 0, the high-speed oscillator enable in bit 1, and the source select in bits 3:2. Select value 3 means PLL and values 0 to 2 are non-PLL sources. The fields drive `ls_osc_en`, `hs_osc_en` and `src_sel`.
- R5: Address 0x0C bit 0 is the PLL power enable and drives `pll_pwr`.
- R6: Address 0x10 bits 3:0 hold the PLL multiplier (`pll_mult`). A write there changes the field only when the bank is unlocked, PLL power is 0 and the select is 0 to 2. In any other case the write is dropped.
- R7: Any dropped write (a lock violation, or a multiplier write refused by the PLL interlock) sets the flag read at 0x20 bit 0 and shown on `reject_flag`. The flag stays set until a write to 0x20 with bit 0 = 1 clears it.
- R8: Address 0x14 holds the 8-bit wait count in bits 15:8 and the fast-tick mode bit in bit 2.
- R9: A `wake` pulse loads the wait count. If the count is nonzero, `clock_ready` is 0 from the next cycle until the count has been decremented to zero. If the count is zero, `clock_ready` stays 1.
- R10: The wait counts only strobes of `src_tick[src_sel]`, using the select value current at each cycle. Strobes of other sources have no effect.
- R11: With the mode bit at 1, every strobe decrements the count. With the mode bit at 0, one decrement happens every 256 strobes.
- R12: Reads are allowed in any lock state. Unmapped addresses read 0. Unlocked writes to 0x00 and 0x04 change nothing and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Byte address for reads and writes |
| bus_wdata | input | 16 | Write value |
| bus_rdata | output | 16 | Read value for `bus_addr` |
| wake | input | 1 | Sleep-release pulse that starts the wait |
| src_tick | input | 4 | One strobe per clock source, indexed by select value |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| src_sel | output | 2 | Clock source select |
| pll_pwr | output | 1 | PLL power enable |
| pll_mult | output | 4 | PLL multiplier setting |
| reject_flag | output | 1 | Sticky flag for a dropped write |
| clock_ready | output | 1 | High when no stabilization wait is running |

## Verification
The embedded assertions check, on every cycle, the rules that need only one edge of history. A key write opens or closes the bank. A locked write leaves the configuration unchanged. The multiplier holds while the PLL is busy. Any dropped write raises the flag. A wake pulse gives the right readiness on the next cycle. The remaining count never grows without a wake. The exact length of a wait in fast and slow mode, and the fact that only the selected source's strobes advance it, can only be shown by the bench scenarios. The same holds for an unlock persisting across long mixed write traffic. These are compared cycle by cycle against the bench's own model.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 2;
  localparam int MULT_W = 4;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 8;
  localparam int NSRC   = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] A_OSC   = 6'h08;
  localparam logic [ADDR_W-1:0] A_PLL   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_MUL   = 6'h10;
  localparam logic [ADDR_W-1:0] A_WAIT  = 6'h14;
  localparam logic [ADDR_W-1:0] A_STAT  = 6'h20;
  localparam logic [ADDR_W-1:0] A_KEY   = 6'h24;
  localparam logic [ADDR_W-1:0] A_GUARD_LAST = 6'h14;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'h0096;
  localparam logic [SEL_W-1:0]  SEL_PLL    = 2'd3;

  typedef struct packed {
    logic              ls;
    logic              hs;
    logic [SEL_W-1:0]  sel;
    logic              pll;
    logic [MULT_W-1:0] mult;
    logic [CNT_W-1:0]  wcnt;
    logic              fast;
  } cfg_t;
endpackage

// File: rtl/clkcfg_lock.sv
module clkcfg_lock
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  logic key_wr;
  assign key_wr = wr && (addr == A_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (wdata == UNLOCK_KEY);
  end

  // R3
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata == UNLOCK_KEY) |=> unlocked);
  // R3
  other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata != UNLOCK_KEY) |=> !unlocked);
  // R3
  lock_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(unlocked));
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              unlocked,
  output cfg_t              cfg,
  output logic              reject,
  output logic [DATA_W-1:0] rdata
);
  logic guard_hit, pll_busy, lock_viol, pll_viol, wr_ok;

  assign guard_hit = wr && (addr <= A_GUARD_LAST);
  assign pll_busy  = cfg.pll || (cfg.sel == SEL_PLL);
  assign wr_ok     = guard_hit && unlocked;
  assign lock_viol = guard_hit && !unlocked;
  assign pll_viol  = wr_ok && (addr == A_MUL) && pll_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.ls   <= 1'b1;
      cfg.hs   <= 1'b1;
      cfg.sel  <= '0;
      cfg.pll  <= 1'b0;
      cfg.mult <= '0;
      cfg.wcnt <= '1;
      cfg.fast <= 1'b0;
    end else if (wr_ok) begin
      case (addr)
        A_OSC: begin
          cfg.ls  <= wdata[0];
          cfg.hs  <= wdata[1];
          cfg.sel <= wdata[2 +: SEL_W];
        end
        A_PLL:  cfg.pll <= wdata[0];
        A_MUL:  if (!pll_busy) cfg.mult <= wdata[MULT_W-1:0];
        A_WAIT: begin
          cfg.wcnt <= wdata[8 +: CNT_W];
          cfg.fast <= wdata[2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   reject <= 1'b0;
    else if (lock_viol || pll_viol)               reject <= 1'b1;
    else if (wr && addr == A_STAT && wdata[0])    reject <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_OSC:  rdata[2 + SEL_W - 1:0] = {cfg.sel, cfg.hs, cfg.ls};
      A_PLL:  rdata[0] = cfg.pll;
      A_MUL:  rdata[MULT_W-1:0] = cfg.mult;
      A_WAIT: begin
        rdata[8 +: CNT_W] = cfg.wcnt;
        rdata[2]          = cfg.fast;
      end
      A_STAT: rdata[0] = reject;
      A_KEY:  rdata[0] = unlocked;
      default: ;
    endcase
  end

  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_hit && !unlocked) |=> $stable(cfg));
  // R6
  mult_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_MUL && (cfg.pll || cfg.sel == SEL_PLL)) |=> $stable(cfg.mult));
  // R7
  reject_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_viol || pll_viol) |=> reject);
endmodule

// File: rtl/clkcfg_wait.sv
module clkcfg_wait
  import clkcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake,
  input  logic [CNT_W-1:0] load,
  input  logic             fast,
  input  logic             tick_in,
  output logic             ready
);
  logic             waiting;
  logic [CNT_W-1:0] rem;
  logic [PRE_W-1:0] pre;
  logic             step;

  assign step  = fast || (pre == '1);
  assign ready = !waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      rem     <= '0;
      pre     <= '0;
    end else if (wake) begin
      waiting <= (load != '0);
      rem     <= load;
      pre     <= '0;
    end else if (waiting && tick_in) begin
      if (!fast) pre <= pre + 1'b1;
      if (step) begin
        rem <= rem - 1'b1;
        if (rem == CNT_W'(1)) waiting <= 1'b0;
      end
    end
  end

  // R9
  wake_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && load != '0) |=> !ready);
  // R9
  wake_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && load == '0) |=> ready);
  // R9
  rem_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |=> (rem <= $past(rem)));
endmodule

// File: rtl/clkcfg_guard.sv
module clkcfg_guard
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wake,
  input  logic [NSRC-1:0]   src_tick,
  output logic              ls_osc_en,
  output logic              hs_osc_en,
  output logic [SEL_W-1:0]  src_sel,
  output logic              pll_pwr,
  output logic [MULT_W-1:0] pll_mult,
  output logic              reject_flag,
  output logic              clock_ready
);
  logic unlocked;
  cfg_t cfg;
  logic sel_tick;

  clkcfg_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .unlocked(unlocked)
  );

  clkcfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .unlocked(unlocked), .cfg(cfg),
    .reject(reject_flag), .rdata(bus_rdata)
  );

  assign sel_tick = src_tick[cfg.sel];

  clkcfg_wait u_wait (
    .clk(clk), .rst_n(rst_n), .wake(wake), .load(cfg.wcnt),
    .fast(cfg.fast), .tick_in(sel_tick), .ready(clock_ready)
  );

  assign ls_osc_en = cfg.ls;
  assign hs_osc_en = cfg.hs;
  assign src_sel   = cfg.sel;
  assign pll_pwr   = cfg.pll;
  assign pll_mult  = cfg.mult;
endmodule

// File: tb/clkcfg_guard_tb.sv
module clkcfg_guard_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        wake = 0;
  logic [3:0]  src_tick = 0;
  logic        ls_osc_en, hs_osc_en, pll_pwr, reject_flag, clock_ready;
  logic [1:0]  src_sel;
  logic [3:0]  pll_mult;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkcfg_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake(wake),
    .src_tick(src_tick), .ls_osc_en(ls_osc_en), .hs_osc_en(hs_osc_en),
    .src_sel(src_sel), .pll_pwr(pll_pwr), .pll_mult(pll_mult),
    .reject_flag(reject_flag), .clock_ready(clock_ready)
  );

  // behavioural reference model
  int m_ls, m_hs, m_sel, m_pll, m_mult, m_wcnt, m_fast, m_flag, m_unl;
  int m_wait, m_rem, m_pre;

  always @(posedge clk) begin
    int tick;
    if (!rst_n) begin
      m_ls = 1; m_hs = 1; m_sel = 0; m_pll = 0; m_mult = 0;
      m_wcnt = 255; m_fast = 0; m_flag = 0; m_unl = 0;
      m_wait = 0; m_rem = 0; m_pre = 0;
    end else begin
      if (wake) begin
        m_wait = (m_wcnt != 0); m_rem = m_wcnt; m_pre = 0;
      end else if (m_wait && src_tick[m_sel]) begin
        if (m_fast) tick = 1;
        else begin tick = (m_pre == 255); m_pre = (m_pre + 1) % 256; end
        if (tick) begin m_rem = m_rem - 1; if (m_rem == 0) m_wait = 0; end
      end
      if (bus_wr) begin
        if (bus_addr <= 6'h14) begin
          if (!m_unl) m_flag = 1;
          else if (bus_addr == 6'h08) begin
            m_ls = bus_wdata[0]; m_hs = bus_wdata[1]; m_sel = bus_wdata[3:2];
          end else if (bus_addr == 6'h0C) m_pll = bus_wdata[0];
          else if (bus_addr == 6'h10) begin
            if (m_pll || m_sel == 3) m_flag = 1; else m_mult = bus_wdata[3:0];
          end else if (bus_addr == 6'h14) begin
            m_wcnt = bus_wdata[15:8]; m_fast = bus_wdata[2];
          end
        end else if (bus_addr == 6'h20) begin
          if (bus_wdata[0]) m_flag = 0;
        end else if (bus_addr == 6'h24) m_unl = (bus_wdata == 16'h0096);
      end
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      8'h08: return m_ls + 2 * m_hs + 4 * m_sel;
      8'h0C: return m_pll;
      8'h10: return m_mult;
      8'h14: return m_wcnt * 256 + 4 * m_fast;
      8'h20: return m_flag;
      8'h24: return m_unl;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(ls_osc_en == m_ls[0] && hs_osc_en == m_hs[0], "R4 osc", {hs_osc_en, ls_osc_en}, m_hs*2+m_ls);
      chk(src_sel == m_sel[1:0], "R4 sel", src_sel, m_sel);
      chk(pll_pwr == m_pll[0], "R5", pll_pwr, m_pll);
      chk(pll_mult == m_mult[3:0], "R6", pll_mult, m_mult);
      chk(reject_flag == m_flag[0], "R7", reject_flag, m_flag);
      chk(clock_ready == !m_wait, "R9 R10 R11 ready", clock_ready, !m_wait);
      chk(bus_rdata == 16'(exp_rd(bus_addr)), "R12 read", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string req);
    @(negedge clk); bus_addr = a; #3;
    chk(bus_rdata == e, req, bus_rdata, e);
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1;
    @(negedge clk); wake = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'h08, 16'h0003, "R1");
    rd(6'h0C, 16'h0000, "R1");
    rd(6'h10, 16'h0000, "R1");
    rd(6'h14, 16'hFF00, "R1");
    rd(6'h24, 16'h0000, "R1");
    chk(clock_ready == 1, "R1 ready", clock_ready, 1);
    // R2 locked write dropped, R7 flag
    wr(6'h08, 16'h0004);
    rd(6'h08, 16'h0003, "R2");
    rd(6'h20, 16'h0001, "R7 set");
    wr(6'h20, 16'h0001);
    rd(6'h20, 16'h0000, "R7 clear");
    // R3 unlock persists
    wr(6'h24, 16'h0096);
    rd(6'h24, 16'h0001, "R3 open");
    wr(6'h08, 16'h0006);
    rd(6'h08, 16'h0006, "R4");
    wr(6'h14, 16'h0504);
    rd(6'h14, 16'h0504, "R8");
    wr(6'h10, 16'h000A);
    rd(6'h10, 16'h000A, "R6 accept");
    // R6 interlock: PLL powered
    wr(6'h0C, 16'h0001);
    rd(6'h0C, 16'h0001, "R5");
    wr(6'h10, 16'h0003);
    rd(6'h10, 16'h000A, "R6 powered");
    rd(6'h20, 16'h0001, "R7 interlock");
    wr(6'h20, 16'h0001);
    wr(6'h0C, 16'h0000);
    // R6 interlock: PLL selected
    wr(6'h08, 16'h000E);
    wr(6'h10, 16'h0005);
    rd(6'h10, 16'h000A, "R6 selected");
    wr(6'h20, 16'h0001);
    wr(6'h08, 16'h000B);
    wr(6'h10, 16'h0005);
    rd(6'h10, 16'h0005, "R6 sel2");
    // R12 unimplemented write has no effect
    wr(6'h00, 16'hFFFF);
    rd(6'h00, 16'h0000, "R12");
    rd(6'h20, 16'h0000, "R12 no flag");
    rd(6'h24, 16'h0001, "R3 persist");
    // R10 only selected source counts (sel = 2), fast mode count 5
    src_tick = 4'b1011;
    pulse_wake();
    repeat (10) @(negedge clk);
    #3 chk(clock_ready == 0, "R10 other sources", clock_ready, 0);
    src_tick = 4'b0100;
    repeat (4) @(negedge clk);
    #3 chk(clock_ready == 0, "R11 fast not yet", clock_ready, 0);
    @(negedge clk); #3 chk(clock_ready == 1, "R11 fast done", clock_ready, 1);
    // R9 zero count
    wr(6'h14, 16'h0004);
    pulse_wake();
    #3 chk(clock_ready == 1, "R9 zero", clock_ready, 1);
    // R11 slow mode, count 2
    wr(6'h14, 16'h0200);
    src_tick = 4'b1111;
    pulse_wake();
    repeat (511) @(negedge clk);
    #3 chk(clock_ready == 0, "R11 slow not yet", clock_ready, 0);
    @(negedge clk); #3 chk(clock_ready == 1, "R11 slow done", clock_ready, 1);
    // R3 relock
    wr(6'h24, 16'h0000);
    rd(6'h24, 16'h0000, "R3 close");
    wr(6'h08, 16'h0000);
    rd(6'h08, 16'h000B, "R2 relocked");
    // mixed traffic against the model
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      bus_wr    = ($urandom % 3) == 0;
      bus_addr  = 6'(($urandom % 10) * 4);
      bus_wdata = (($urandom % 4) == 0) ? 16'h0096 : 16'($urandom);
      if (bus_addr == 6'h14) bus_wdata[15:8] = 8'($urandom % 6);
      wake      = ($urandom % 40) == 0;
      src_tick  = 4'($urandom);
    end
    @(negedge clk); bus_wr = 0; wake = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule